// File: doc/BRIEF.md
# Auxiliary RAM Bank Switch Controller

This block sits beside a CPU's 16-bit address bus and keeps a small set of soft-switch flags that decide, region by region, whether main RAM or auxiliary RAM answers an access. Software flips a flag by touching a specific address in the I/O page at $C0xx. Some of these flags change only on a write; others change on any access. From the flags the block decodes registered bank selects for the $0200–$BFFF range, with read and write handled separately. It also decodes a single select that moves zero page and stack ($0000–$01FF) to the auxiliary bank.

The $0200–$BFFF range is split into three regions. The general region is $0200–$03FF, $0800–$1FFF and $4000–$BFFF. The text window is $0400–$07FF. The graphics window is $2000–$3FFF. The general region always follows the generic aux-read and aux-write flags. The two video windows can instead be steered by the display-page flag. This happens only while the 80-column store mode is on, and for the graphics window only when the hi-res flag is also set.

The block raises a one-cycle pulse whenever the decoded region map really changes, and a second pulse whenever the zero-page select really changes. The owner uses these pulses to refresh its memory decode. The RAM arrays and the video logic are outside the block.

Top module: `auxram_bank_ctrl`

## Requirements
- R1: A synchronous active-low reset clears every flag. On the edge after reset all six region selects, the zero-page select and both change pulses are 0, which means main memory everywhere.
- R2: A valid write access sets or clears a write-only flag. The odd address sets it and the even address clears it: $C000/$C001 for 80-store, $C002/$C003 for aux-read, $C004/$C005 for aux-write, $C008/$C009 for alternate zero page. The outputs show the new value after the clock edge that samples the access.
- R3: A read access to any address in $C000–$C00B leaves every flag and every output unchanged.
- R4: Any valid access, read or write, to $C054 or $C055 sets the page-2 flag to bit 0 of the address. Any valid access to $C056 or $C057 sets the hi-res flag the same way.
- R5: The general-region read select equals the aux-read flag, and the general-region write select equals the aux-write flag.
- R6: While 80-store is 1, both the read and the write select of the text window equal the page-2 flag.
- R7: While 80-store and hi-res are both 1, both graphics-window selects equal the page-2 flag. While 80-store is 1 and hi-res is 0, the graphics window uses the general-region selects.
- R8: While 80-store is 0, the text window and the graphics window both use the general-region read and write selects.
- R9: The zero-page select equals the alternate-zero-page flag.
- R10: map_chg is high for exactly the cycle after an edge at which at least one of the six region selects changed. It stays low when a flag changes without changing the decoded map, and when a write repeats the current value.
- R11: zp_chg is high for exactly the cycle after an edge at which the zero-page select changed, and never on a write that repeats the current value.
- R12: The following have no effect: accesses with acc_valid low, addresses outside $C000–$C057, and the unassigned switch addresses $C006, $C007, $C00A and $C00B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is on the bus this cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 16 | CPU address of the access |
| rd_base | output | 1 | General region reads from aux RAM |
| wr_base | output | 1 | General region writes to aux RAM |
| rd_txt | output | 1 | $0400–$07FF reads from aux RAM |
| wr_txt | output | 1 | $0400–$07FF writes to aux RAM |
| rd_hgr | output | 1 | $2000–$3FFF reads from aux RAM |
| wr_hgr | output | 1 | $2000–$3FFF writes to aux RAM |
| zp_sel | output | 1 | $0000–$01FF uses aux RAM |
| map_chg | output | 1 | One-cycle pulse: region map changed |
| zp_chg | output | 1 | One-cycle pulse: zero-page select changed |

## Verification
A flag latched wrongly shows at the ports on the first edge after the access. It shows only through the region whose decode currently depends on that flag. A corrupted page-2 or hi-res flag can therefore stay hidden until 80-store is turned on, so the sequence toggles each flag in both enabled and disabled override states. A change detector that compares against the wrong history shows up as a missing or extra pulse in that same cycle. This is why redundant writes, and flag changes that leave the map untouched, are checked for silence.

// File: rtl/auxram_pkg.sv
// Package: auxram_pkg
// Shared types and switch address offsets for the auxiliary RAM bank switch
// controller. Offsets are relative to the soft-switch I/O page.
package auxram_pkg;

    // Raw soft-switch flags.
    typedef struct packed {
        logic store80;
        logic aux_rd;
        logic aux_wr;
        logic alt_zp;
        logic page2;
        logic hires;
    } flags_t;

    // Read/write bank select for one region (1 = auxiliary).
    typedef struct packed {
        logic rd;
        logic wr;
    } sel_t;

    // Decoded selects for the three regions in $0200-$BFFF.
    typedef struct packed {
        sel_t base;
        sel_t txt;
        sel_t hgr;
    } map_t;

    // Pair index (offset >> 1) of each write-only switch.
    localparam logic [6:0] PAIR_STORE80 = 7'h00;
    localparam logic [6:0] PAIR_AUX_RD  = 7'h01;
    localparam logic [6:0] PAIR_AUX_WR  = 7'h02;
    localparam logic [6:0] PAIR_ALT_ZP  = 7'h04;
    // Pair index of each read-or-write video switch.
    localparam logic [6:0] PAIR_PAGE2   = 7'h2A;
    localparam logic [6:0] PAIR_HIRES   = 7'h2B;
    // Highest offset this block decodes in the switch page.
    localparam logic [7:0] LAST_OFFSET  = 8'h57;

endpackage

// File: rtl/auxram_switch_reg.sv
// Module: auxram_switch_reg
// Decodes bus accesses to the soft-switch page and holds the flag register.
// Presents both the next-state flags (for registered downstream decode) and
// the current flags. Assumes one access per cycle, qualified by acc_valid.
module auxram_switch_reg
    import auxram_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter logic [7:0] SW_PAGE  = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output flags_t            flg_d,
    output flags_t            flg_q
);
    localparam int PAGE_LSB = ADDR_W - 8;

    logic       in_page;
    logic [6:0] pair;
    logic       val;
    logic       wo_hit;

    // Qualify the access as one aimed at the decoded switch range.
    always_comb begin
        in_page = acc_valid
                  && (acc_addr[ADDR_W-1:PAGE_LSB] == SW_PAGE)
                  && (acc_addr[7:0] <= LAST_OFFSET);
        pair    = acc_addr[7:1];
        val     = acc_addr[0];
        wo_hit  = in_page && acc_wr;
    end

    // Compute the next flag set from the current access.
    always_comb begin
        flg_d = flg_q;
        if (wo_hit) begin
            case (pair)
                PAIR_STORE80: flg_d.store80 = val;
                PAIR_AUX_RD:  flg_d.aux_rd  = val;
                PAIR_AUX_WR:  flg_d.aux_wr  = val;
                PAIR_ALT_ZP:  flg_d.alt_zp  = val;
                default: ;
            endcase
        end
        if (in_page) begin
            case (pair)
                PAIR_PAGE2: flg_d.page2 = val;
                PAIR_HIRES: flg_d.hires = val;
                default: ;
            endcase
        end
    end

    // Hold the flags; reset selects main memory everywhere.
    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    // R3: a read in $C000-$C00B leaves the write-only flags alone.
    a_r3_read_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_wr && acc_addr[ADDR_W-1:PAGE_LSB] == SW_PAGE
         && acc_addr[7:0] <= 8'h0B)
        |=> ({flg_q.store80, flg_q.aux_rd, flg_q.aux_wr, flg_q.alt_zp}
             == $past({flg_q.store80, flg_q.aux_rd, flg_q.aux_wr, flg_q.alt_zp})));

    // R12: an idle bus changes no flag.
    a_r12_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(flg_q));

endmodule

// File: rtl/auxram_region_map.sv
// Module: auxram_region_map
// Pure combinational decode of the flags into region selects. The two video
// windows are overridden by the page-2 flag only under 80-store; the graphics
// window additionally needs hi-res.
module auxram_region_map
    import auxram_pkg::*;
(
    input  flags_t flg,
    output map_t   map,
    output logic   zp
);
    localparam int N_WIN = 2;

    sel_t base_sel;
    sel_t page_sel;
    logic [N_WIN-1:0] ovr;
    sel_t win [N_WIN];

    // Build the general and page-steered selects.
    always_comb begin
        base_sel.rd = flg.aux_rd;
        base_sel.wr = flg.aux_wr;
        page_sel.rd = flg.page2;
        page_sel.wr = flg.page2;
        ovr[0]      = flg.store80;
        ovr[1]      = flg.store80 && flg.hires;
    end

    // One mux per video window: page-steered when overridden, else general.
    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        assign win[w] = ovr[w] ? page_sel : base_sel;
    end

    // Assemble the output map and the zero-page select.
    always_comb begin
        map.base = base_sel;
        map.txt  = win[0];
        map.hgr  = win[1];
        zp       = flg.alt_zp;
    end

endmodule

// File: rtl/auxram_change_det.sv
// Module: auxram_change_det
// Registers the decoded map and zero-page select and raises one-cycle pulses
// when either registered value changes. Assumes map_d/zp_d are the next-state
// decode, so outputs and pulses move on the same edge.
module auxram_change_det
    import auxram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  map_t map_d,
    input  logic zp_d,
    output map_t map_q,
    output logic zp_q,
    output logic map_chg,
    output logic zp_chg
);
    // Register the selects and flag any difference from the held value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            zp_q    <= 1'b0;
            map_chg <= 1'b0;
            zp_chg  <= 1'b0;
        end else begin
            map_q   <= map_d;
            zp_q    <= zp_d;
            map_chg <= (map_d != map_q);
            zp_chg  <= (zp_d != zp_q);
        end
    end

    // R10: the map pulse marks exactly the cycles whose map differs from before.
    a_r10_map_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (map_chg == (map_q != $past(map_q))));

    // R11: the zero-page pulse marks exactly a zero-page select change.
    a_r11_zp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zp_chg == (zp_q != $past(zp_q))));

endmodule

// File: rtl/auxram_bank_ctrl.sv
// Module: auxram_bank_ctrl (top)
// Auxiliary RAM bank switch controller: watches the CPU bus, keeps the
// soft-switch flags, and drives registered bank selects plus change pulses.
// Assumes a single synchronous clock and one bus access per cycle.
module auxram_bank_ctrl
    import auxram_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [7:0] SW_PAGE = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rd_base,
    output logic              wr_base,
    output logic              rd_txt,
    output logic              wr_txt,
    output logic              rd_hgr,
    output logic              wr_hgr,
    output logic              zp_sel,
    output logic              map_chg,
    output logic              zp_chg
);
    flags_t flg_d;
    flags_t flg_q;
    map_t   map_d;
    map_t   map_q;
    logic   zp_d;

    auxram_switch_reg #(.ADDR_W(ADDR_W), .SW_PAGE(SW_PAGE)) u_sw (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .flg_d     (flg_d),
        .flg_q     (flg_q)
    );

    auxram_region_map u_map (
        .flg (flg_d),
        .map (map_d),
        .zp  (zp_d)
    );

    auxram_change_det u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_d   (map_d),
        .zp_d    (zp_d),
        .map_q   (map_q),
        .zp_q    (zp_sel),
        .map_chg (map_chg),
        .zp_chg  (zp_chg)
    );

    // Unpack the registered map onto the output pins.
    always_comb begin
        rd_base = map_q.base.rd;
        wr_base = map_q.base.wr;
        rd_txt  = map_q.txt.rd;
        wr_txt  = map_q.txt.wr;
        rd_hgr  = map_q.hgr.rd;
        wr_hgr  = map_q.hgr.wr;
    end

    // R1: reset leaves main memory selected everywhere and no pulse.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> ({rd_base, wr_base, rd_txt, wr_txt, rd_hgr, wr_hgr,
                     zp_sel, map_chg, zp_chg} == '0));

    // R5: general region tracks the generic read/write flags.
    a_r5_base_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_base == flg_q.aux_rd && wr_base == flg_q.aux_wr));

    // R6: under 80-store the text window follows page 2.
    a_r6_txt_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && flg_q.store80) |-> (rd_txt == flg_q.page2 && wr_txt == flg_q.page2));

    // R7: under 80-store with hi-res the graphics window follows page 2.
    a_r7_hgr_page: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && flg_q.store80 && flg_q.hires)
        |-> (rd_hgr == flg_q.page2 && wr_hgr == flg_q.page2));

    // R8: without 80-store both windows copy the general region.
    a_r8_windows_base: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !flg_q.store80)
        |-> (rd_txt == rd_base && wr_txt == wr_base && rd_hgr == rd_base && wr_hgr == wr_base));

    // R9: zero-page select tracks its flag.
    a_r9_zp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zp_sel == flg_q.alt_zp));

    // R12: an idle bus raises no pulse on the next cycle.
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !acc_valid) |=> (!map_chg && !zp_chg));

endmodule

// File: tb/test_auxram_bank_ctrl.sv
// Bench for auxram_bank_ctrl: a vector table walked by one loop, then
// directed reset checks. Output vector order:
// {rd_base, wr_base, rd_txt, wr_txt, rd_hgr, wr_hgr, zp_sel, map_chg, zp_chg}
module test_auxram_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_addr = 16'h0000;
    logic rd_base, wr_base, rd_txt, wr_txt, rd_hgr, wr_hgr, zp_sel, map_chg, zp_chg;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    auxram_bank_ctrl i_auxram_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .rd_base(rd_base), .wr_base(wr_base),
        .rd_txt(rd_txt), .wr_txt(wr_txt), .rd_hgr(rd_hgr), .wr_hgr(wr_hgr),
        .zp_sel(zp_sel), .map_chg(map_chg), .zp_chg(zp_chg)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        v;
        logic        w;
        logic [15:0] a;
        logic [8:0]  e;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  1'b1, 1'b1, 16'hC003, 9'b101010010}, // R2 R8: aux-read on
        '{4'd3,  1'b1, 1'b0, 16'hC002, 9'b101010000}, // R3: read ignored
        '{4'd2,  1'b1, 1'b1, 16'hC005, 9'b111111010}, // R2: aux-write on
        '{4'd10, 1'b1, 1'b1, 16'hC005, 9'b111111000}, // R10: repeat, no pulse
        '{4'd10, 1'b1, 1'b1, 16'hC055, 9'b111111000}, // R10 R4: page2 hidden
        '{4'd10, 1'b1, 1'b1, 16'hC001, 9'b111111000}, // R10 R6: 80-store, same map
        '{4'd6,  1'b1, 1'b0, 16'hC054, 9'b110011010}, // R6 R4: read clears page2
        '{4'd7,  1'b1, 1'b0, 16'hC057, 9'b110000010}, // R7: hi-res on
        '{4'd5,  1'b1, 1'b1, 16'hC002, 9'b010000010}, // R5: aux-read off
        '{4'd9,  1'b1, 1'b1, 16'hC009, 9'b010000101}, // R9 R11: alt zp on
        '{4'd11, 1'b1, 1'b1, 16'hC009, 9'b010000100}, // R11: repeat, no pulse
        '{4'd12, 1'b1, 1'b1, 16'hC006, 9'b010000100}, // R12: unassigned
        '{4'd12, 1'b1, 1'b1, 16'hC00B, 9'b010000100}, // R12: unassigned
        '{4'd12, 1'b1, 1'b1, 16'hC103, 9'b010000100}, // R12: outside page
        '{4'd12, 1'b0, 1'b1, 16'hC003, 9'b010000100}, // R12: idle bus
        '{4'd4,  1'b1, 1'b0, 16'hC055, 9'b011111110}, // R4 R7: page2 on
        '{4'd7,  1'b1, 1'b1, 16'hC056, 9'b011101110}, // R7: hi-res off
        '{4'd8,  1'b1, 1'b1, 16'hC000, 9'b010101110}, // R8: 80-store off
        '{4'd3,  1'b1, 1'b0, 16'hC001, 9'b010101100}, // R3: read ignored
        '{4'd5,  1'b1, 1'b1, 16'hC004, 9'b000000110}, // R5: aux-write off
        '{4'd11, 1'b1, 1'b1, 16'hC008, 9'b000000001}, // R11: alt zp off
        '{4'd12, 1'b1, 1'b1, 16'hC058, 9'b000000000}  // R12: just past range
    };

    function automatic logic [8:0] outs();
        return {rd_base, wr_base, rd_txt, wr_txt, rd_hgr, wr_hgr, zp_sel, map_chg, zp_chg};
    endfunction

    task automatic check(input int req, input logic [8:0] exp, input string what);
        n_checks++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, outs(), exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [15:0] a);
        acc_valid = v;
        acc_wr    = w;
        acc_addr  = a;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(1, 9'b0, "R1 reset state");
        rst_n = 1'b1;
        // Walk the table: drive at a falling edge, check at the next one.
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].w, TBL[i].a);
            @(negedge clk);
            check(int'(TBL[i].req), TBL[i].e, $sformatf("vector %0d", i));
        end
        drive(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        // R1: mid-run reset after setting flags clears everything.
        drive(1'b1, 1'b1, 16'hC003);
        @(negedge clk);
        drive(1'b1, 1'b1, 16'hC009);
        @(negedge clk);
        check(9, 9'b101010101, "setup before reset");
        drive(1'b1, 1'b1, 16'hC005);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 9'b0, "R1 reset overrides access");
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        check(1, 9'b0, "R1 quiet after reset");
        // R4: page-2 write with 80-store on reaches the text window.
        drive(1'b1, 1'b1, 16'hC001);
        @(negedge clk);
        check(10, 9'b0, "R10 80-store alone no change");
        drive(1'b1, 1'b1, 16'hC055);
        @(negedge clk);
        check(4, 9'b001100010, "R4 write to page2");
        drive(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        check(10, 9'b001100000, "R10 pulse lasts one cycle");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule